// File: doc/BRIEF.md
# Compressed Instruction Decoder

This block classifies one 16-bit compressed instruction word for a 32-bit integer core. It is purely combinational. From the word alone it produces an operation code, an illegal flag, and the destination and two source register indices that the operation uses. It does not produce immediates, and it does not read the register file. A fetch or issue stage places it in front of the execute logic, and the expanded operation then follows the same path as a full-width instruction.

The decode works as a tree. The two low bits pick the quadrant. Bits [15:13] pick the slot within that quadrant. A few slots are shared by several operations, and sub-fields or zero-field tests tell those operations apart. Register fields that are three bits wide address x8 to x15. The forms that work relative to the stack pointer name x2 as their base. Floating-point slots are reported as illegal, and so are reserved slots, the quadrant-3 pattern and the all-zero word.

Top module: `cdec_top`

## Requirements
- R1: A word whose bits [1:0] are 11 is not a compressed instruction. It gives illegal_o=1 and op_o=0.
- R2: The op_o codes are: 0 illegal, 1 ADDI4SPN, 2 LW, 3 SW, 4 ADDI, 5 JAL, 6 LI, 7 ADDI16SP, 8 LUI, 9 SRLI, 10 SRAI, 11 ANDI, 12 SUB, 13 XOR, 14 OR, 15 AND, 16 J, 17 BEQZ, 18 BNEZ, 19 SLLI, 20 LWSP, 21 JR, 22 MV, 23 EBREAK, 24 JALR, 25 ADD, 26 SWSP. illegal_o is 1 exactly when op_o is 0, and in that case rd_o, rs1_o and rs2_o are all 0. An index that an operation does not use is driven as 0.
- R3: In quadrant 00 with funct3 000, the word is ADDI4SPN with rd=8+bits[4:2] and rs1=2. If bits [12:5] are all zero, the word is illegal instead, and this case includes the all-zero word.
- R4: In quadrant 00, funct3 010 is LW (rd=8+[4:2], rs1=8+[9:7]) and funct3 110 is SW (rs1=8+[9:7], rs2=8+[4:2]).
- R5: In quadrant 00, funct3 values 001, 011, 101 and 111 (floating-point load and store) and the reserved value 100 are illegal.
- R6: In quadrant 01, the funct3 values decode as follows. 000 is ADDI (rd=rs1=[11:7]). 010 is LI (rd=[11:7]). 001 is JAL (rd=1). 101 is J. 110 is BEQZ and 111 is BNEZ, both with rs1=8+[9:7].
- R7: In quadrant 01 with funct3 011, the word is ADDI16SP (rd=rs1=2) when [11:7]=2. Otherwise it is LUI with rd=[11:7].
- R8: In quadrant 01 with funct3 100, bits [11:10] select the operation: 00 is SRLI, 01 is SRAI, 10 is ANDI, and 11 is the register group. In the register group, [6:5] select 00 SUB, 01 XOR, 10 OR or 11 AND. All of these use rd=rs1=8+[9:7], and the register group also uses rs2=8+[4:2].
- R9: In quadrant 10, funct3 000 is SLLI (rd=rs1=[11:7]), 010 is LWSP (rd=[11:7], rs1=2) and 110 is SWSP (rs1=2, rs2=[6:2]).
- R10: In quadrant 10 with funct3 100 and bit 12 clear, the word is JR (rs1=[11:7]) if [6:2]=0. Otherwise it is MV (rd=[11:7], rs2=[6:2]).
- R11: In quadrant 10 with funct3 100 and bit 12 set, the word is EBREAK if [11:2]=0. It is JALR (rd=1, rs1=[11:7]) if only [6:2]=0. Otherwise it is ADD (rd=rs1=[11:7], rs2=[6:2]).
- R12: In quadrant 10, funct3 values 001, 011, 101 and 111 (floating-point stack-relative load and store) are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction word |
| op_o | output | 5 | Operation code (see R2) |
| illegal_o | output | 1 | Word is not a legal integer compressed instruction |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |

## Verification
Random words seldom reach the zero-field corners. EBREAK needs ten specific bits to be clear, and the illegal ADDI4SPN needs eight. Random words also rarely hit the one rd value that turns LUI into ADDI16SP. The stimulus therefore begins with a directed list that places each of these boundaries next to its neighbouring encoding, one bit away on either side. A long run of random words then covers the remaining field combinations against a behavioural model.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int ILEN  = 16;
  localparam int IDX_W = 5;
  localparam int OP_W  = 5;

  typedef enum logic [OP_W-1:0] {
    C_ILLEGAL  = 5'd0,  C_ADDI4SPN = 5'd1,  C_LW    = 5'd2,  C_SW    = 5'd3,
    C_ADDI     = 5'd4,  C_JAL      = 5'd5,  C_LI    = 5'd6,  C_ADDI16 = 5'd7,
    C_LUI      = 5'd8,  C_SRLI     = 5'd9,  C_SRAI  = 5'd10, C_ANDI  = 5'd11,
    C_SUB      = 5'd12, C_XOR      = 5'd13, C_OR    = 5'd14, C_AND   = 5'd15,
    C_J        = 5'd16, C_BEQZ     = 5'd17, C_BNEZ  = 5'd18, C_SLLI  = 5'd19,
    C_LWSP     = 5'd20, C_JR       = 5'd21, C_MV    = 5'd22, C_EBRK  = 5'd23,
    C_JALR     = 5'd24, C_ADD      = 5'd25, C_SWSP  = 5'd26
  } cop_e;

  typedef struct packed {
    cop_e             op;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rs1;
    logic [IDX_W-1:0] rs2;
  } cdec_t;

  localparam logic [IDX_W-1:0] X0_IDX = IDX_W'(0);
  localparam logic [IDX_W-1:0] RA_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(2);

  localparam cdec_t CDEC_BAD = '{op: C_ILLEGAL, rd: X0_IDX, rs1: X0_IDX, rs2: X0_IDX};

  // short register field -> x8..x15
  function automatic logic [IDX_W-1:0] cx(input logic [2:0] f);
    return IDX_W'({2'b01, f});
  endfunction
endpackage

// File: rtl/cdec_q0.sv
module cdec_q0
  import cdec_pkg::*;
(
  input  logic [ILEN-1:0] ins,
  output cdec_t           dec
);
  logic sink_unused;
  assign sink_unused = ^ins[1:0];

  always_comb begin
    dec = CDEC_BAD;
    unique case (ins[15:13])
      3'b000: if (ins[12:5] != 8'd0) begin
        dec.op  = C_ADDI4SPN;
        dec.rd  = cx(ins[4:2]);
        dec.rs1 = SP_IDX;
      end
      3'b010: begin
        dec.op  = C_LW;
        dec.rd  = cx(ins[4:2]);
        dec.rs1 = cx(ins[9:7]);
      end
      3'b110: begin
        dec.op  = C_SW;
        dec.rs1 = cx(ins[9:7]);
        dec.rs2 = cx(ins[4:2]);
      end
      default: dec = CDEC_BAD;
    endcase
  end
endmodule

// File: rtl/cdec_q1.sv
module cdec_q1
  import cdec_pkg::*;
(
  input  logic [ILEN-1:0] ins,
  output cdec_t           dec
);
  logic sink_unused;
  assign sink_unused = ^{ins[12], ins[1:0]};

  logic [IDX_W-1:0] full_rd;
  logic [IDX_W-1:0] sh_rd;
  assign full_rd = ins[11:7];
  assign sh_rd   = cx(ins[9:7]);

  always_comb begin
    dec = CDEC_BAD;
    unique case (ins[15:13])
      3'b000: begin dec.op = C_ADDI; dec.rd = full_rd; dec.rs1 = full_rd; end
      3'b001: begin dec.op = C_JAL;  dec.rd = RA_IDX; end
      3'b010: begin dec.op = C_LI;   dec.rd = full_rd; end
      3'b011: if (full_rd == SP_IDX) begin
        dec.op = C_ADDI16; dec.rd = SP_IDX; dec.rs1 = SP_IDX;
      end else begin
        dec.op = C_LUI; dec.rd = full_rd;
      end
      3'b100: begin
        dec.rd  = sh_rd;
        dec.rs1 = sh_rd;
        unique case (ins[11:10])
          2'b00: dec.op = C_SRLI;
          2'b01: dec.op = C_SRAI;
          2'b10: dec.op = C_ANDI;
          default: begin
            dec.rs2 = cx(ins[4:2]);
            unique case (ins[6:5])
              2'b00:   dec.op = C_SUB;
              2'b01:   dec.op = C_XOR;
              2'b10:   dec.op = C_OR;
              default: dec.op = C_AND;
            endcase
          end
        endcase
      end
      3'b101: dec.op = C_J;
      3'b110: begin dec.op = C_BEQZ; dec.rs1 = sh_rd; end
      default: begin dec.op = C_BNEZ; dec.rs1 = sh_rd; end
    endcase
  end
endmodule

// File: rtl/cdec_q2.sv
module cdec_q2
  import cdec_pkg::*;
(
  input  logic [ILEN-1:0] ins,
  output cdec_t           dec
);
  logic sink_unused;
  assign sink_unused = ^ins[1:0];

  logic [IDX_W-1:0] f_a;
  logic [IDX_W-1:0] f_b;
  logic             b_zero;
  assign f_a    = ins[11:7];
  assign f_b    = ins[6:2];
  assign b_zero = (f_b == X0_IDX);

  always_comb begin
    dec = CDEC_BAD;
    unique case (ins[15:13])
      3'b000: begin dec.op = C_SLLI; dec.rd = f_a; dec.rs1 = f_a; end
      3'b010: begin dec.op = C_LWSP; dec.rd = f_a; dec.rs1 = SP_IDX; end
      3'b110: begin dec.op = C_SWSP; dec.rs1 = SP_IDX; dec.rs2 = f_b; end
      3'b100: begin
        if (!ins[12]) begin
          if (b_zero) begin dec.op = C_JR; dec.rs1 = f_a; end
          else begin dec.op = C_MV; dec.rd = f_a; dec.rs2 = f_b; end
        end else if (b_zero && f_a == X0_IDX) begin
          dec.op = C_EBRK;
        end else if (b_zero) begin
          dec.op = C_JALR; dec.rd = RA_IDX; dec.rs1 = f_a;
        end else begin
          dec.op = C_ADD; dec.rd = f_a; dec.rs1 = f_a; dec.rs2 = f_b;
        end
      end
      default: dec = CDEC_BAD;
    endcase
  end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
(
  input  logic [ILEN-1:0]  instr_i,
  output logic [OP_W-1:0]  op_o,
  output logic             illegal_o,
  output logic [IDX_W-1:0] rd_o,
  output logic [IDX_W-1:0] rs1_o,
  output logic [IDX_W-1:0] rs2_o
);
  cdec_t dq0, dq1, dq2, sel;

  cdec_q0 u_q0 (.ins(instr_i), .dec(dq0));
  cdec_q1 u_q1 (.ins(instr_i), .dec(dq1));
  cdec_q2 u_q2 (.ins(instr_i), .dec(dq2));

  always_comb begin
    unique case (instr_i[1:0])
      2'b00:   sel = dq0;
      2'b01:   sel = dq1;
      2'b10:   sel = dq2;
      default: sel = CDEC_BAD;
    endcase
  end

  assign op_o      = sel.op;
  assign illegal_o = (sel.op == C_ILLEGAL);
  assign rd_o      = sel.rd;
  assign rs1_o     = sel.rs1;
  assign rs2_o     = sel.rs2;

  always_comb begin
    if (instr_i[1:0] == 2'b11)
      a_r1_quad3_illegal: assert (illegal_o && op_o == '0) else $error("R1 quad3");
    if (illegal_o)
      a_r2_illegal_no_regs: assert (rd_o == '0 && rs1_o == '0 && rs2_o == '0) else $error("R2 regs");
    if (instr_i == '0)
      a_r3_zero_word: assert (illegal_o) else $error("R3 zero word");
    if (op_o == C_LWSP || op_o == C_SWSP || op_o == C_ADDI4SPN || op_o == C_ADDI16)
      a_r9_sp_base: assert (rs1_o == SP_IDX) else $error("R9 sp base");
    if (op_o >= C_SRLI && op_o <= C_AND)
      a_r8_short_regs: assert (rd_o[4:3] == 2'b01 && rd_o == rs1_o) else $error("R8 short regs");
    if (op_o == C_EBRK)
      a_r11_ebreak_fields: assert (instr_i[11:2] == '0 && instr_i[12]) else $error("R11 ebreak");
  end
endmodule

// File: tb/sim_cdec_top.sv
module sim_cdec_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr;
  logic [4:0]  op, rd, rs1, rs2;
  logic        ill;
  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cdec_top u0 (.instr_i(instr), .op_o(op), .illegal_o(ill),
               .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2));

  // behavioural model written from the requirements
  task automatic model(input logic [15:0] w, output int eo, output int erd,
                       output int ers1, output int ers2, output string tag);
    int q, f, a, b, sa, sb;
    q = w[1:0]; f = w[15:13];
    a = w[11:7]; b = w[6:2];
    sa = 8 + w[9:7]; sb = 8 + w[4:2];
    eo = 0; erd = 0; ers1 = 0; ers2 = 0; tag = "R2";
    if (q == 3) tag = "R1";
    else if (q == 0) begin
      if (f == 0) begin
        tag = "R3";
        if (w[12:5] != 0) begin eo = 1; erd = sb; ers1 = 2; end
      end else if (f == 2) begin tag = "R4"; eo = 2; erd = sb; ers1 = sa; end
      else if (f == 6) begin tag = "R4"; eo = 3; ers1 = sa; ers2 = sb; end
      else tag = "R5";
    end else if (q == 1) begin
      tag = "R6";
      case (f)
        0: begin eo = 4; erd = a; ers1 = a; end
        1: begin eo = 5; erd = 1; end
        2: begin eo = 6; erd = a; end
        3: begin tag = "R7"; if (a == 2) begin eo = 7; erd = 2; ers1 = 2; end
                  else begin eo = 8; erd = a; end end
        4: begin
          tag = "R8"; erd = sa; ers1 = sa;
          if (w[11:10] != 3) eo = 9 + w[11:10];
          else begin eo = 12 + w[6:5]; ers2 = sb; end
        end
        5: eo = 16;
        6: begin eo = 17; ers1 = sa; end
        default: begin eo = 18; ers1 = sa; end
      endcase
    end else begin
      if (f == 0) begin tag = "R9"; eo = 19; erd = a; ers1 = a; end
      else if (f == 2) begin tag = "R9"; eo = 20; erd = a; ers1 = 2; end
      else if (f == 6) begin tag = "R9"; eo = 26; ers1 = 2; ers2 = b; end
      else if (f == 4 && w[12] == 0) begin
        tag = "R10";
        if (b == 0) begin eo = 21; ers1 = a; end
        else begin eo = 22; erd = a; ers2 = b; end
      end else if (f == 4) begin
        tag = "R11";
        if (a == 0 && b == 0) eo = 23;
        else if (b == 0) begin eo = 24; erd = 1; ers1 = a; end
        else begin eo = 25; erd = a; ers1 = a; ers2 = b; end
      end else tag = "R12";
    end
  endtask

  task automatic check_now(input logic [15:0] w);
    int eo, erd, ers1, ers2; string tag;
    model(w, eo, erd, ers1, ers2, tag);
    n_run++;
    if (op != eo[4:0] || ill != (eo == 0) || rd != erd[4:0] || rs1 != ers1[4:0] || rs2 != ers2[4:0]) begin
      n_fail++;
      $display("FAIL %s word=%h got op=%0d ill=%0b rd=%0d rs1=%0d rs2=%0d exp op=%0d ill=%0b rd=%0d rs1=%0d rs2=%0d",
               tag, w, op, ill, rd, rs1, rs2, eo, eo == 0, erd, ers1, ers2);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(posedge clk); #1 instr = w;
    @(negedge clk); check_now(w);
  endtask

  logic [15:0] directed [0:27] = '{
    16'h0000, 16'h0020, 16'h1000, 16'h0004,          // R3 boundary, all-zero word
    16'h4088, 16'hC088, 16'h2000, 16'h8000,          // R4, R5
    16'hFFFF, 16'h0003,                              // R1
    16'h6101, 16'h6181, 16'h6285, 16'h2001,          // R7 both sides, R6 JAL
    16'h8C89, 16'h8CA9, 16'h8CC9, 16'h8CE9, 16'h8809, // R8 group + ANDI
    16'h9002, 16'h9006, 16'h9082, 16'h8082, 16'h852E, 16'h952E, // R11, R10
    16'h4082, 16'hC00A, 16'h2002                     // R9, R12
  };

  initial begin
    rst_n = 1'b0; instr = 16'h0000;
    @(negedge clk); check_now(16'h0000);  // reset-time state: R3 zero word illegal
    @(posedge clk); #1 rst_n = 1'b1;
    foreach (directed[i]) apply(directed[i]);
    for (int k = 0; k < 4000; k++) apply(16'($urandom));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R2 got running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule